// File: doc/BRIEF.md
# Multiprocessor Startup Sequencer

This block runs alongside the boot processor and brings the remaining processors of a shared-memory system out of reset. One pulse on its start input makes it seed a shared processor tally with the value 1, which counts the boot processor itself. It then hands three command words to the interprocessor interrupt unit, all addressed to every processor except the sender. The first is a reset-class wake message. The second and third are start-up messages that carry the entry page vector. After each hand-off it waits until the unit reports that the message has left. It then holds for a fixed number of clock cycles: a long gap after the wake message and a short gap after each start-up message.

After the final gap the sequencer samples the tally, which the woken processors have been incrementing. It reports the sampled value together with a flag that says whether the value matches the expected processor count. Both gap lengths are parameters in clock cycles. With a 50 MHz clock, 10 ms is 500000 cycles and 200 µs is 10000 cycles.

The command output is a valid/ready stream. The sequencer raises `cmd_valid_o` with a complete word and keeps both the valid and the word unchanged until `cmd_ready_i` is seen high at a clock edge. The interrupt unit must show its pending status on `ipi_busy_i` no later than the cycle after it accepts a word. All other pins are plain levels or pulses.

Top module: `mp_wake_seq`

## Requirements
- R1: After reset `cmd_valid_o`, `cnt_set_o`, `done_o` and `all_up_o` are 0 and `cpu_cnt_o` is 0.
- R2: A start pulse seen in idle or finished state gives a one-cycle `cnt_set_o` pulse in the next cycle, meaning "set the shared tally to 1". `cmd_valid_o` rises in the cycle after that pulse.
- R3: The first command word is 0x000C4500. In that word, bits 19:18 = 11 select all-excluding-self, bit 15 = 0 selects edge trigger, bit 14 = 1 selects assert, and bits 10:8 = 101 select the wake (reset-class) message.
- R4: The second and third command words are 0x000C4600 OR'd with the 8-bit parameter VECTOR, where bits 10:8 = 110 select start-up and bits 7:0 hold the vector.
- R5: While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_valid_o` stays high and `cmd_word_o` does not change.
- R6: After a word is accepted the sequencer stays put while `ipi_busy_i` is 1. It moves on in the first cycle in which `ipi_busy_i` reads 0, and issues nothing new before then.
- R7: After the wake message, `cmd_valid_o` rises again exactly INIT_WAIT_CYC + 1 cycles after the cycle in which `ipi_busy_i` was first seen low.
- R8: After the first start-up message, the next `cmd_valid_o` rises exactly SIPI_WAIT_CYC + 1 cycles after the cycle in which `ipi_busy_i` was first seen low.
- R9: After the second start-up message, `done_o` rises exactly SIPI_WAIT_CYC + 2 cycles after busy is first seen low. At the same time `cpu_cnt_o` shows the value of `cpu_cnt_i` sampled one cycle earlier, and `all_up_o` is 1 exactly when that value equals EXPECT_CNT.
- R10: A start pulse while a sequence is running is ignored. No second `cnt_set_o` pulse occurs, and exactly three words are issued.
- R11: `done_o`, `all_up_o` and `cpu_cnt_o` hold after completion until the next start pulse, which begins a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| cmd_valid_o | output | 1 | Command word valid |
| cmd_ready_i | input | 1 | Interrupt unit accepts the word |
| cmd_word_o | output | 32 | Interrupt command word |
| ipi_busy_i | input | 1 | Delivery pending status from the interrupt unit |
| cnt_set_o | output | 1 | Pulse: set shared tally to 1 |
| cpu_cnt_i | input | CNT_W | Shared processor tally |
| done_o | output | 1 | Sequence finished |
| all_up_o | output | 1 | Sampled tally equals EXPECT_CNT |
| cpu_cnt_o | output | CNT_W | Sampled tally |

## Verification
Each result has a fixed latency. The tally-set pulse appears one cycle after start, and the first command valid appears two cycles after start. A command that follows a gap appears gap + 1 cycles after the cycle in which busy first reads low. Done rises one cycle later than such a command would. The bench keeps a free-running cycle counter and records the cycle of each stimulus. It then checks the output in both the cycle before the due cycle and the due cycle itself, so a result that arrives early or late is reported. All sampling happens at the falling edge, after all register updates.

// File: rtl/mp_wake_pkg.sv
package mp_wake_pkg;

  typedef enum logic [2:0] {
    WK_IDLE, WK_SEED, WK_SEND, WK_POLL, WK_WAIT, WK_SAMPLE, WK_DONE
  } wk_state_t;

  localparam logic [2:0] MSG_WAKE    = 3'b101;
  localparam logic [2:0] MSG_STARTUP = 3'b110;
  localparam logic [1:0] DEST_OTHERS = 2'b11;

  function automatic logic [31:0] icr_word(input logic [2:0] msg, input logic [7:0] vec);
    logic [31:0] w;
    w        = '0;
    w[19:18] = DEST_OTHERS;
    w[15]    = 1'b0;          // edge trigger
    w[14]    = 1'b1;          // assert level
    w[10:8]  = msg;
    w[7:0]   = vec;
    return w;
  endfunction

endpackage

// File: rtl/mp_wake_delay.sv
module mp_wake_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R7 / R8: the gap counter steps down by one each cycle
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mp_wake_cmd.sv
module mp_wake_cmd #(
  parameter logic [7:0] VECTOR = 8'h11
) (
  input  logic [1:0]  step_i,
  output logic [31:0] word_o
);
  import mp_wake_pkg::*;

  always_comb begin
    if (step_i == 2'd0) word_o = icr_word(MSG_WAKE, 8'h00);
    else                word_o = icr_word(MSG_STARTUP, VECTOR);
  end
endmodule

// File: rtl/mp_wake_fsm.sv
module mp_wake_fsm #(
  parameter int CNT_W      = 8,
  parameter int EXPECT_CNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmd_ready_i,
  input  logic             ipi_busy_i,
  input  logic             dly_zero_i,
  input  logic [CNT_W-1:0] cpu_cnt_i,
  output logic [1:0]       step_o,
  output logic             cmd_valid_o,
  output logic             cnt_set_o,
  output logic             dly_load_o,
  output logic             dly_long_o,
  output logic             done_o,
  output logic             all_up_o,
  output logic [CNT_W-1:0] cpu_cnt_o
);
  import mp_wake_pkg::*;

  localparam logic [1:0] LAST_STEP = 2'd2;

  wk_state_t        state_q, state_d;
  logic [1:0]       step_q, step_d;
  logic [CNT_W-1:0] cnt_q;
  logic             ok_q;
  logic             idle_like;

  assign idle_like = (state_q == WK_IDLE) || (state_q == WK_DONE);

  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    dly_load_o = 1'b0;
    unique case (state_q)
      WK_IDLE, WK_DONE: if (start_i) state_d = WK_SEED;
      WK_SEED: begin
        step_d  = 2'd0;
        state_d = WK_SEND;
      end
      WK_SEND: if (cmd_ready_i) state_d = WK_POLL;
      WK_POLL: if (!ipi_busy_i) begin
        dly_load_o = 1'b1;
        state_d    = WK_WAIT;
      end
      WK_WAIT: if (dly_zero_i) begin
        if (step_q == LAST_STEP) state_d = WK_SAMPLE;
        else begin
          step_d  = step_q + 2'd1;
          state_d = WK_SEND;
        end
      end
      WK_SAMPLE: state_d = WK_DONE;
      default:   state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      step_q  <= 2'd0;
      cnt_q   <= '0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      if (state_q == WK_SAMPLE) begin
        cnt_q <= cpu_cnt_i;
        ok_q  <= (cpu_cnt_i == CNT_W'(EXPECT_CNT));
      end
    end
  end

  assign step_o      = step_q;
  assign dly_long_o  = (step_q == 2'd0);
  assign cmd_valid_o = (state_q == WK_SEND);
  assign cnt_set_o   = (state_q == WK_SEED);
  assign done_o      = (state_q == WK_DONE);
  assign all_up_o    = ok_q;
  assign cpu_cnt_o   = cnt_q;

  // R6: no progress while delivery is pending
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WK_POLL && ipi_busy_i) |=> (state_q == WK_POLL));
  // R2: the seed pulse lasts one cycle
  a_r2_seed_once: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_set_o |=> !cnt_set_o);
  // R10: a seed only follows a start taken while idle or finished
  a_r10_seed_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_set_o) |-> ($past(start_i) && $past(idle_like)));
  // R11: the finished state holds until a new start
  a_r11_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(cpu_cnt_o) && $stable(all_up_o)));
endmodule

// File: rtl/mp_wake_seq.sv
module mp_wake_seq #(
  parameter int         INIT_WAIT_CYC = 500000,
  parameter int         SIPI_WAIT_CYC = 10000,
  parameter logic [7:0] VECTOR        = 8'h11,
  parameter int         CNT_W         = 8,
  parameter int         EXPECT_CNT    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [31:0]      cmd_word_o,
  input  logic             ipi_busy_i,
  output logic             cnt_set_o,
  input  logic [CNT_W-1:0] cpu_cnt_i,
  output logic             done_o,
  output logic             all_up_o,
  output logic [CNT_W-1:0] cpu_cnt_o
);
  localparam int MAX_WAIT = (INIT_WAIT_CYC > SIPI_WAIT_CYC) ? INIT_WAIT_CYC : SIPI_WAIT_CYC;
  localparam int DLY_W    = $clog2(MAX_WAIT + 1);

  logic [1:0]       step;
  logic             dly_load, dly_long, dly_zero;
  logic [DLY_W-1:0] dly_val;

  assign dly_val = dly_long ? DLY_W'(INIT_WAIT_CYC - 1) : DLY_W'(SIPI_WAIT_CYC - 1);

  mp_wake_fsm #(.CNT_W(CNT_W), .EXPECT_CNT(EXPECT_CNT)) fsm_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_ready_i(cmd_ready_i),
    .ipi_busy_i(ipi_busy_i), .dly_zero_i(dly_zero), .cpu_cnt_i(cpu_cnt_i),
    .step_o(step), .cmd_valid_o(cmd_valid_o), .cnt_set_o(cnt_set_o),
    .dly_load_o(dly_load), .dly_long_o(dly_long), .done_o(done_o),
    .all_up_o(all_up_o), .cpu_cnt_o(cpu_cnt_o)
  );

  mp_wake_delay #(.W(DLY_W)) dly_i (
    .clk(clk), .rst_n(rst_n), .load_i(dly_load), .load_val_i(dly_val), .zero_o(dly_zero)
  );

  mp_wake_cmd #(.VECTOR(VECTOR)) cmd_i (
    .step_i(step), .word_o(cmd_word_o)
  );

  // R5: back-pressure keeps the offer intact
  a_r5_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_word_o)));
  // R3 / R4: every offered word targets all other processors with assert level
  a_r4_word_shape: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (cmd_word_o[19:18] == 2'b11 && cmd_word_o[14] && !cmd_word_o[15]));
endmodule

// File: tb/mp_wake_seq_tb.sv
module mp_wake_seq_tb_top;
  localparam int         NI   = 40;
  localparam int         NS   = 12;
  localparam logic [7:0] VEC  = 8'h11;
  localparam int         EXPN = 4;
  localparam logic [31:0] W_WAKE = 32'h000C4500;
  localparam logic [31:0] W_SIPI = 32'h000C4600 | {24'h0, VEC};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       cmd_ready_i = 1'b0;
  logic       ipi_busy_i = 1'b0;
  logic [7:0] cpu_cnt_i = 8'd0;
  logic       cmd_valid_o, cnt_set_o, done_o, all_up_o;
  logic [31:0] cmd_word_o;
  logic [7:0] cpu_cnt_o;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int set_seen = 0;

  always #10 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cnt_set_o) set_seen <= set_seen + 1;
  end

  mp_wake_seq #(.INIT_WAIT_CYC(NI), .SIPI_WAIT_CYC(NS), .VECTOR(VEC),
                .CNT_W(8), .EXPECT_CNT(EXPN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i), .cmd_word_o(cmd_word_o), .ipi_busy_i(ipi_busy_i),
    .cnt_set_o(cnt_set_o), .cpu_cnt_i(cpu_cnt_i), .done_o(done_o),
    .all_up_o(all_up_o), .cpu_cnt_o(cpu_cnt_o)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  // offer handling: stall, accept, hold busy; returns cycle in which busy reads low
  task automatic serve_cmd(input logic [31:0] exp_word, input string req, input int stall,
                           input int busy_len, output int c0);
    check(cmd_valid_o == 1'b1, req, "valid present", 32'(cmd_valid_o), 1);
    check(cmd_word_o == exp_word, req, "command word", cmd_word_o, exp_word);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check(cmd_valid_o && cmd_word_o == exp_word, "R5", "held under back-pressure",
            cmd_word_o, exp_word);
    end
    cmd_ready_i = 1'b1;
    ipi_busy_i  = 1'b1;
    @(negedge clk);
    cmd_ready_i = 1'b0;
    for (int i = 1; i < busy_len; i++) begin
      check(!cmd_valid_o && !done_o, "R6", "quiet while busy", 32'(cmd_valid_o), 0);
      @(negedge clk);
    end
    ipi_busy_i = 1'b0;
    c0 = cyc;
  endtask

  task automatic run_seq(input int stall, input int busy_len, input int aps, input bit poke);
    int s, c0, c1, c2, sets0;
    logic [7:0] exp_cnt;
    sets0 = set_seen;
    @(negedge clk);
    s = cyc;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(cnt_set_o == 1'b1, "R2", "seed pulse one cycle after start", 32'(cnt_set_o), 1);
    check(done_o == 1'b0, "R11", "done drops on restart", 32'(done_o), 0);
    cpu_cnt_i = 8'd1;
    @(negedge clk);
    check(cnt_set_o == 1'b0 && cyc == s + 2, "R2", "seed pulse ends", 32'(cnt_set_o), 0);
    serve_cmd(W_WAKE, "R3", stall, busy_len, c0);
    if (poke) begin
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_until(c0 + NI);
    check(cmd_valid_o == 1'b0, "R7", "no offer before long gap ends", 32'(cmd_valid_o), 0);
    @(negedge clk);
    serve_cmd(W_SIPI, "R4", stall, busy_len, c1);
    cpu_cnt_i = cpu_cnt_i + 8'(aps);
    wait_until(c1 + NS);
    check(cmd_valid_o == 1'b0, "R8", "no offer before short gap ends", 32'(cmd_valid_o), 0);
    @(negedge clk);
    serve_cmd(W_SIPI, "R8", stall, busy_len, c2);
    exp_cnt = 8'(1 + aps);
    wait_until(c2 + NS + 1);
    check(done_o == 1'b0 && !cmd_valid_o, "R9", "not done before sample", 32'(done_o), 0);
    @(negedge clk);
    check(done_o == 1'b1, "R9", "done after final gap", 32'(done_o), 1);
    check(cpu_cnt_o == exp_cnt, "R9", "sampled tally", 32'(cpu_cnt_o), 32'(exp_cnt));
    check(all_up_o == (exp_cnt == 8'(EXPN)), "R9", "match flag", 32'(all_up_o),
          32'(exp_cnt == 8'(EXPN)));
    check(set_seen - sets0 == 1, "R10", "single seed per run", 32'(set_seen - sets0), 1);
    cpu_cnt_i = 8'd99;
    repeat (5) @(negedge clk);
    check(done_o && cpu_cnt_o == exp_cnt && !cmd_valid_o, "R11", "result held",
          32'(cpu_cnt_o), 32'(exp_cnt));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(!cmd_valid_o && !cnt_set_o && !done_o && !all_up_o && cpu_cnt_o == 0,
          "R1", "reset outputs", {cmd_valid_o, cnt_set_o, done_o, all_up_o, cpu_cnt_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!cmd_valid_o && !done_o, "R1", "idle without start", 32'(cmd_valid_o), 0);
  endtask

  task automatic t_plain;       run_seq(0, 3, 3, 1'b0); endtask
  task automatic t_backpress;   run_seq(4, 1, 2, 1'b0); endtask
  task automatic t_ignore_poke; run_seq(1, 5, 3, 1'b1); endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_backpress();
    t_ignore_poke();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule